// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is a free-running interval timer for a processor core. A count register advances by one on every tick, and software programs a compare register with the value at which it wants to be interrupted. A tick is one clock, or a fixed number of clocks set by a parameter. When the count reaches the compare value, a sticky pending flag is set. One line of an interrupt vector is then raised. A 3-bit routing input selects which line.

Software acknowledges the interrupt by writing the compare register, which usually also sets up the next interval. The count can be read back at any time and written directly. A freeze input stops counting and suppresses matches without losing the count value or the divider phase. The count wraps modulo 2^32, so an interval that crosses the top of the range behaves like any other.

Top module: `cmp_timer`

## Requirements
- R1: While reset is asserted and until the first counting edge after reset, the count reads 1, the pending flag is 0 and all interrupt lines are 0. The compare register resets to 0, so an untouched compare matches when the count wraps to 0.
- R2: While `freeze` is 1, the count keeps its value. A count write still loads the written value at the next clock edge.
- R3: While `freeze` is 1, no match is detected, and the pending flag cannot go from 0 to 1.
- R4: In a cycle where `freeze` is 0, the count equals compare and compare is not being written, the pending flag is 1 after the next clock edge.
- R5: `irq_lines` is all zero while the pending flag is 0. While the flag is 1, only bit `irq_lines[route]` is 1, with `route` taken as an unsigned index from 0 to 7.
- R6: A compare write makes the pending flag 0 after that edge. This holds even when a match is detected in the same cycle: the write wins.
- R7: Once set, the pending flag stays 1 after the count moves past compare. It clears only on a compare write or a reset.
- R8: The count wraps from 0xFFFFFFFF to 0x00000000, and a match across the wrap is detected like any other.
- R9: A count write in the same cycle as a tick loads the written value; that tick's increment is dropped.
- R10: The count increments once per TICK_DIV unfrozen clocks. The divider phase holds while frozen, so 2k unfrozen cycles give exactly k increments when TICK_DIV is 2, however the freeze time is placed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freeze | input | 1 | 1 stops counting and match detection |
| route | input | 3 | Index of the interrupt line to drive |
| cnt_wr_en | input | 1 | Load the count this cycle |
| cnt_wr_data | input | 32 | Value to load into the count |
| cmp_wr_en | input | 1 | Load compare and clear the pending flag |
| cmp_wr_data | input | 32 | Value to load into compare |
| cnt_rd | output | 32 | Current count |
| tick_pending | output | 1 | Sticky timer-pending flag |
| irq_lines | output | 8 | Interrupt vector, one-hot or zero |

## Verification
Two collisions are the main concern.

- **Compare write against match.** A compare write and a match can land in the same cycle. The bench provokes this by loading count and compare with equal values and then writing compare again in the very next cycle. It expects the pending flag to read 0 after that edge.
- **Count write against tick.** A count write can coincide with a divider tick. Back-to-back count writes guarantee that one of them lands on a tick edge. Each is judged by reading exactly the written value after its edge.

Random traffic then mixes both collisions with freezes and route changes. Every output is compared each cycle with a model built from the requirements.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned RST_COUNT_VAL = 1;
  localparam int unsigned RST_CMP_VAL   = 0;
endpackage

// File: rtl/cmp_timer_rstsync.sv
module cmp_timer_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick #(
  parameter int unsigned DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      logic unused_pins;
      assign unused_pins = clk ^ rst_n;
      assign tick = !freeze;
    end else begin : g_div
      localparam int unsigned DW = $clog2(DIV);
      localparam logic [DW-1:0] LAST = DW'(DIV - 1);
      logic [DW-1:0] div_q, div_d;

      // phase advances only on unfrozen cycles, so no tick is lost or added
      always_comb begin
        div_d = div_q;
        if (!freeze) begin
          div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      assign tick = !freeze && (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count
  import cmp_timer_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_q
);
  logic [W-1:0] cnt_d;

  // a software load outranks the increment (R9); the sum wraps (R8)
  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)     cnt_d = wr_data;
    else if (tick) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_COUNT_VAL);
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cmp_timer_match.sv
module cmp_timer_match
  import cmp_timer_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned LINES = 8,
  parameter int unsigned RW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic [W-1:0]     cnt,
  input  logic             cmp_wr_en,
  input  logic [W-1:0]     cmp_wr_data,
  input  logic [RW-1:0]    route,
  output logic [W-1:0]     cmp_q,
  output logic             pending_q,
  output logic [LINES-1:0] irq_lines
);
  logic [W-1:0] cmp_d;
  logic         pending_d;
  logic         hit;

  assign hit = !freeze && (cnt == cmp_q);

  always_comb begin
    cmp_d     = cmp_q;
    pending_d = pending_q;
    if (cmp_wr_en) begin
      cmp_d     = cmp_wr_data;
      pending_d = 1'b0;
    end else if (hit) begin
      pending_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q     <= W'(RST_CMP_VAL);
      pending_q <= 1'b0;
    end else begin
      cmp_q     <= cmp_d;
      pending_q <= pending_d;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign irq_lines[i] = pending_q && (route == RW'(i));
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned TICK_DIV  = 1,
  parameter int unsigned IRQ_LINES = 8,
  localparam int unsigned ROUTE_W  = $clog2(IRQ_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 freeze,
  input  logic [ROUTE_W-1:0]   route,
  input  logic                 cnt_wr_en,
  input  logic [CNT_W-1:0]     cnt_wr_data,
  input  logic                 cmp_wr_en,
  input  logic [CNT_W-1:0]     cmp_wr_data,
  output logic [CNT_W-1:0]     cnt_rd,
  output logic                 tick_pending,
  output logic [IRQ_LINES-1:0] irq_lines
);
  logic             rst_i;
  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;

  cmp_timer_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  cmp_timer_tick #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_i),
    .freeze (freeze),
    .tick   (tick)
  );

  cmp_timer_count #(.W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_i),
    .tick    (tick),
    .wr_en   (cnt_wr_en),
    .wr_data (cnt_wr_data),
    .cnt_q   (cnt_q)
  );

  cmp_timer_match #(.W(CNT_W), .LINES(IRQ_LINES), .RW(ROUTE_W)) u_match (
    .clk         (clk),
    .rst_n       (rst_i),
    .freeze      (freeze),
    .cnt         (cnt_q),
    .cmp_wr_en   (cmp_wr_en),
    .cmp_wr_data (cmp_wr_data),
    .route       (route),
    .cmp_q       (cmp_q),
    .pending_q   (tick_pending),
    .irq_lines   (irq_lines)
  );

  assign cnt_rd = cnt_q;
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             freeze,
  input logic             cnt_wr_en,
  input logic [W-1:0]     cnt_wr_data,
  input logic             cmp_wr_en,
  input logic [W-1:0]     cnt_rd,
  input logic [W-1:0]     cmp_val,
  input logic             tick_pending,
  input logic [LINES-1:0] irq_lines
);
  p_freeze_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_wr_en) |=> (cnt_rd == $past(cnt_rd)));

  p_freeze_nomatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !tick_pending) |=> !tick_pending);

  p_match_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !cmp_wr_en && (cnt_rd == cmp_val)) |=> tick_pending);

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));

  p_line_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pending == (irq_lines != '0));

  p_cmp_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_en |=> !tick_pending);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_pending && !cmp_wr_en) |=> tick_pending);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (cnt_rd == $past(cnt_wr_data)));
endmodule

bind cmp_timer cmp_timer_chk #(.W(CNT_W), .LINES(IRQ_LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_i),
  .freeze       (freeze),
  .cnt_wr_en    (cnt_wr_en),
  .cnt_wr_data  (cnt_wr_data),
  .cmp_wr_en    (cmp_wr_en),
  .cnt_rd       (cnt_rd),
  .cmp_val      (cmp_q),
  .tick_pending (tick_pending),
  .irq_lines    (irq_lines)
);

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
  localparam int unsigned TDIV = 2;

  logic        clk;
  logic        rst_n;
  logic        freeze;
  logic [2:0]  route;
  logic        cnt_wr_en;
  logic [31:0] cnt_wr_data;
  logic        cmp_wr_en;
  logic [31:0] cmp_wr_data;
  logic [31:0] cnt_rd;
  logic        tick_pending;
  logic [7:0]  irq_lines;

  int    errors = 0;
  int    checks = 0;
  bit    done   = 0;
  string cur_tag = "R1";

  cmp_timer #(.CNT_W(32), .TICK_DIV(TDIV), .IRQ_LINES(8)) u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .route(route),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .cnt_rd(cnt_rd), .tick_pending(tick_pending), .irq_lines(irq_lines)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // requirement model: reset release after two edges, then R2..R10 per edge
  logic        m_s1, m_s2, m_pend;
  logic [31:0] m_cnt, m_cmp;
  int          m_div;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0;
      m_cnt <= 32'd1; m_cmp <= 32'd0; m_pend <= 1'b0; m_div <= 0;
    end else begin
      m_s1 <= 1'b1;
      m_s2 <= m_s1;
      if (m_s2) begin
        if (!freeze) m_div <= (m_div == TDIV - 1) ? 0 : m_div + 1;
        if (cnt_wr_en) m_cnt <= cnt_wr_data;
        else if (!freeze && m_div == TDIV - 1) m_cnt <= m_cnt + 32'd1;
        if (cmp_wr_en) begin
          m_cmp  <= cmp_wr_data;
          m_pend <= 1'b0;
        end else if (!freeze && m_cnt == m_cmp) begin
          m_pend <= 1'b1;
        end
      end
    end
  end

  function automatic logic [7:0] exp_lines(input logic p, input logic [2:0] r);
    return p ? (8'd1 << r) : 8'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk({cur_tag, " count"},   cnt_rd, m_cnt);
    chk({cur_tag, " pending"}, {31'd0, tick_pending}, {31'd0, m_pend});
    chk({cur_tag, " lines"},   {24'd0, irq_lines}, {24'd0, exp_lines(m_pend, route)});
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic wr_cnt(input logic [31:0] v);
    cnt_wr_en = 1'b1; cnt_wr_data = v;
    cyc();
    cnt_wr_en = 1'b0;
  endtask

  task automatic wr_cmp(input logic [31:0] v);
    cmp_wr_en = 1'b1; cmp_wr_data = v;
    cyc();
    cmp_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    int          seed_init;
    seed_init = $urandom(32'h5eed_0042);
    rst_n = 1'b0; freeze = 1'b0; route = 3'd5;
    cnt_wr_en = 1'b0; cnt_wr_data = '0; cmp_wr_en = 1'b0; cmp_wr_data = '0;
    repeat (3) @(negedge clk);

    // R1: reset values
    chk("R1 reset count", cnt_rd, 32'd1);
    chk("R1 reset pending", {31'd0, tick_pending}, 32'd0);
    chk("R1 reset lines", {24'd0, irq_lines}, 32'd0);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1/R8: untouched compare is 0, reached by wrapping from near the top
    cur_tag = "R8";
    wr_cnt(32'hFFFF_FFFD);
    repeat (10) cyc();
    chk("R8 wrap match pending", {31'd0, tick_pending}, 32'd1);
    chk("R1 reset compare is zero", {31'd0, tick_pending}, 32'd1);
    chk("R5 routed line 5", {24'd0, irq_lines}, 32'h20);
    route = 3'd2;
    cyc();
    chk("R5 routed line 2", {24'd0, irq_lines}, 32'h04);

    // R6: compare write clears
    cur_tag = "R6";
    wr_cmp(32'd100);
    chk("R6 clear pending", {31'd0, tick_pending}, 32'd0);
    chk("R6 clear lines", {24'd0, irq_lines}, 32'd0);

    // R7: sticky after passing the match
    cur_tag = "R7";
    wr_cmp(32'd200);
    wr_cnt(32'd198);
    repeat (8) cyc();
    chk("R4 match set pending", {31'd0, tick_pending}, 32'd1);
    repeat (20) cyc();
    chk("R7 sticky pending", {31'd0, tick_pending}, 32'd1);
    chk("R7 count moved past", {31'd0, cnt_rd > 32'd200}, 32'd1);

    // R2/R3: freeze
    cur_tag = "R2";
    freeze = 1'b1;
    wr_cmp(32'd52);
    wr_cnt(32'd50);
    chk("R2 write while frozen", cnt_rd, 32'd50);
    repeat (10) cyc();
    chk("R2 count held", cnt_rd, 32'd50);
    cur_tag = "R3";
    wr_cnt(32'd52);
    repeat (6) cyc();
    chk("R3 no match frozen", {31'd0, tick_pending}, 32'd0);
    chk("R3 no line frozen", {24'd0, irq_lines}, 32'd0);
    freeze = 1'b0;
    cur_tag = "R4";
    cyc();
    chk("R4 match after unfreeze", {31'd0, tick_pending}, 32'd1);
    chk("R5 line after unfreeze", {24'd0, irq_lines}, 32'h04);

    // R6: compare write in the same cycle as a match
    cur_tag = "R6";
    wr_cmp(32'd300);
    wr_cnt(32'd300);
    wr_cmp(32'd300);
    chk("R6 write beats match", {31'd0, tick_pending}, 32'd0);

    // R9: back-to-back count writes, one lands on a tick edge
    cur_tag = "R9";
    wr_cnt(32'd1000);
    chk("R9 write one", cnt_rd, 32'd1000);
    wr_cnt(32'd2000);
    chk("R9 write two", cnt_rd, 32'd2000);

    // R10: divider rate and phase kept across freeze
    cur_tag = "R10";
    wr_cmp(32'h8000_0000);
    wr_cnt(32'd5000);
    repeat (3) cyc();
    freeze = 1'b1;
    repeat (7) cyc();
    freeze = 1'b0;
    repeat (5) cyc();
    freeze = 1'b1;
    repeat (4) cyc();
    freeze = 1'b0;
    repeat (4) cyc();
    chk("R10 increments over 12 unfrozen cycles", cnt_rd, 32'd5006);

    // random traffic, all requirements together
    cur_tag = "R4 random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) freeze = ~freeze;
      if (r == 1 || r == 4) begin
        cnt_wr_en = 1'b1;
        cnt_wr_data = ($urandom % 4 == 0) ? (32'hFFFF_FFFC + ($urandom % 4)) : cnt_rd + ($urandom % 3);
      end
      if (r == 2 || r == 4) begin
        cmp_wr_en = 1'b1;
        v = cnt_rd + ($urandom % 8);
        cmp_wr_data = v;
      end
      if (r == 3) route = 3'($urandom);
      cyc();
      cnt_wr_en = 1'b0;
      cmp_wr_en = 1'b0;
    end
    freeze = 1'b0;
    cyc();

    finish_run();
  end
endmodule